// File: doc/BRIEF.md
# DMA Channel Transfer Engine

This block drives the data movement of one DMA channel. A fetcher hands it a node: a byte count, a source address, a destination address and a per-node configuration word. The engine turns that node into a stream of read and write beat requests on a simple request/acknowledge memory port. Each request carries an address, a direction flag and a size code. The engine alternates between a group of read beats and a group of write beats until every byte of the node has been written.

The configuration word sets the read and write access widths, and whether each side's address advances. It also sets the group length of each side, the transfer direction and the number of a peripheral request line. Bit 0 of the word is the channel enable. Software may flip it while a node runs: clearing it freezes the channel at a beat boundary, and setting it continues from the same addresses and count. A readback port shows the bytes still to be written. A one-cycle done pulse tells the fetcher that it may load the next node.

Top module: `dma_xfer_engine`

## Requirements
- R1: After a synchronous reset, `busy`, `mem_req` and `node_done` are low, and `cur_count` and `req_line` are zero.
- R2: A `node_load` pulse is taken only while `busy` is low. A pulse while busy changes neither the beat stream, nor the count, nor the number of done pulses.
- R3: Beats come in groups. A read group has at most cfg[23:20]+1 beats, with `mem_we`=0 and `mem_size`=cfg[13:12]. It is followed by a write group of at most cfg[27:24]+1 beats, with `mem_we`=1 and `mem_size`=cfg[17:16]. A read group ends early when the read bytes are used up, and is skipped when none remain. Size code c means 2^c bytes.
- R4: The read address advances by the read width after each read beat when cfg[31] is set. The write address advances by the write width after each write beat when cfg[30] is set. Otherwise the address stays fixed.
- R5: Direction cfg[3:2] = 1 (memory to peripheral) holds the write address fixed, whatever cfg[30] says. Direction 2 (peripheral to memory) holds the read address fixed, whatever cfg[31] says.
- R6: `cur_count` (16 bits, zero-extended) shows the write bytes still left. Each acknowledged write lowers it by the smaller of the write width and the bytes left. Counts up to 0x1FFC are accepted.
- R7: cfg[0] sets the initial enable. A pulse on `en_wr` writes `en_val` into the enable. While the enable is low, no new beat is issued and the count holds. Setting it again continues from the same addresses.
- R8: The acknowledge of the final write raises `node_done` for exactly one cycle, and `busy` falls in that same cycle. Loading a count of zero gives one done pulse with no beats and no busy cycle.
- R9: Once `mem_req` is raised, it stays high with a stable address, direction and size until `mem_ack` is seen. Each acknowledge completes exactly one beat.
- R10: `req_line` shows cfg[7:4] of the node last accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| node_load | input | 1 | Load a node (taken when idle) |
| node_count | input | 13 | Node byte count |
| node_src | input | 32 | Node source address |
| node_dst | input | 32 | Node destination address |
| node_cfg | input | 32 | Node configuration word |
| en_wr | input | 1 | Write strobe for the channel enable |
| en_val | input | 1 | New enable value |
| busy | output | 1 | Channel holds an unfinished node |
| node_done | output | 1 | One-cycle pulse at node completion |
| cur_count | output | 16 | Write bytes remaining |
| req_line | output | 4 | Peripheral request line of the node |
| mem_req | output | 1 | Beat request |
| mem_we | output | 1 | 1 = write beat, 0 = read beat |
| mem_addr | output | 32 | Beat address |
| mem_size | output | 2 | Beat size code, log2 of bytes |
| mem_ack | input | 1 | Beat acknowledge |

## Verification
Several node shapes are used. Equal read and write widths with both addresses incrementing check the basic grouping. A narrow read side feeding a wide write side shows that the two sides keep separate byte counts and group lengths. Each peripheral direction is run with both increment flags set, so a fixed side is told apart from a flag that is merely honoured. A count that is not a multiple of the write width exposes the short final decrement, and the largest count runs at full width and full group length. Further runs cover the zero-count node, a node loaded disabled, a pause in mid-stream, and a load attempt while busy; a varying acknowledge delay holds requests open.

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RD   = 2'd1,
    PH_WR   = 2'd2
  } phase_t;

  typedef struct packed {
    logic       rd_inc;
    logic       wr_inc;
    logic [1:0] rd_size;
    logic [1:0] wr_size;
    logic [3:0] rd_grp;
    logic [3:0] wr_grp;
    logic [1:0] dir;
  } node_cfg_t;

  localparam logic [1:0] DIR_M2P = 2'd1;
  localparam logic [1:0] DIR_P2M = 2'd2;

  function automatic logic [3:0] beat_bytes(input logic [1:0] code);
    return 4'd1 << code;
  endfunction

endpackage

// File: rtl/dma_side_ptr.sv
module dma_side_ptr #(
  parameter int AW = 32,
  parameter int CW = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic [CW-1:0] load_cnt,
  input  logic          inc,
  input  logic [1:0]    size,
  input  logic          step,
  output logic [AW-1:0] addr,
  output logic [CW-1:0] left,
  output logic          last
);
  logic [CW-1:0] width;
  logic [CW-1:0] take;

  assign width = CW'(dma_eng_pkg::beat_bytes(size));
  assign take  = (left < width) ? left : width;
  assign last  = (left <= width);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr <= '0;
      left <= '0;
    end else if (load) begin
      addr <= load_addr;
      left <= load_cnt;
    end else if (step) begin
      left <= left - take;
      if (inc) addr <= addr + AW'(width);
    end
  end

  assert_count_no_rise_R6: assert property (@(posedge clk) disable iff (rst)
    !load |=> left <= $past(left));

  assert_fixed_addr_R4: assert property (@(posedge clk) disable iff (rst)
    (step && !inc && !load) |=> addr == $past(addr));

endmodule

// File: rtl/dma_beat_seq.sv
module dma_beat_seq #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          start_empty,
  input  logic          en,
  input  logic          ack,
  input  logic [3:0]    rd_grp,
  input  logic [3:0]    wr_grp,
  input  logic          rd_last,
  input  logic          rd_empty,
  input  logic          wr_last,
  input  logic [AW-1:0] rd_addr,
  input  logic [AW-1:0] wr_addr,
  input  logic [1:0]    rd_size,
  input  logic [1:0]    wr_size,
  output logic          busy,
  output logic          done,
  output logic          req,
  output logic          we,
  output logic [AW-1:0] addr,
  output logic [1:0]    size,
  output logic          rd_step,
  output logic          wr_step
);
  import dma_eng_pkg::*;

  phase_t     phase;
  logic [3:0] beat;

  assign busy    = (phase != PH_IDLE);
  assign rd_step = req & ack & ~we;
  assign wr_step = req & ack & we;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      beat  <= '0;
      req   <= 1'b0;
      we    <= 1'b0;
      addr  <= '0;
      size  <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (phase == PH_IDLE) begin
        if (start) begin
          if (start_empty) done <= 1'b1;
          else begin
            phase <= PH_RD;
            beat  <= '0;
          end
        end
      end else if (req) begin
        if (ack) begin
          req  <= 1'b0;
          beat <= beat + 4'd1;
          if (phase == PH_RD) begin
            if (beat == rd_grp || rd_last) begin
              phase <= PH_WR;
              beat  <= '0;
            end
          end else if (wr_last) begin
            phase <= PH_IDLE;
            done  <= 1'b1;
          end else if (beat == wr_grp) begin
            phase <= rd_empty ? PH_WR : PH_RD;
            beat  <= '0;
          end
        end
      end else if (en) begin
        req <= 1'b1;
        if (phase == PH_WR) begin
          we   <= 1'b1;
          addr <= wr_addr;
          size <= wr_size;
        end else begin
          we   <= 1'b0;
          addr <= rd_addr;
          size <= rd_size;
        end
      end
    end
  end

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (req && !ack) |=> (req && $stable(addr) && $stable(we) && $stable(size)));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_busy_fall_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  assert_paused_no_req_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(req) |-> $past(en));

endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine #(
  parameter int AW    = 32,
  parameter int CW    = 13,
  parameter int CNT_W = 16,
  parameter int RLW   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             node_load,
  input  logic [CW-1:0]    node_count,
  input  logic [AW-1:0]    node_src,
  input  logic [AW-1:0]    node_dst,
  input  logic [31:0]      node_cfg,
  input  logic             en_wr,
  input  logic             en_val,
  output logic             busy,
  output logic             node_done,
  output logic [CNT_W-1:0] cur_count,
  output logic [RLW-1:0]   req_line,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [1:0]       mem_size,
  input  logic             mem_ack
);
  import dma_eng_pkg::*;

  localparam int LINE_LSB = 4;

  node_cfg_t     cfg_q;
  logic          en_q;
  logic          load_ok;
  logic          rd_inc, wr_inc;
  logic          rd_step, wr_step;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [CW-1:0] rd_left, wr_left;
  logic          rd_last, wr_last;
  logic          unused_cfg_bits;

  assign unused_cfg_bits = ^{node_cfg[29:28], node_cfg[19:18], node_cfg[15:14], node_cfg[11:8]};

  assign load_ok = node_load & ~busy;
  assign rd_inc  = cfg_q.rd_inc & (cfg_q.dir != DIR_P2M);
  assign wr_inc  = cfg_q.wr_inc & (cfg_q.dir != DIR_M2P);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q    <= '0;
      en_q     <= 1'b0;
      req_line <= '0;
    end else if (load_ok) begin
      cfg_q.rd_inc  <= node_cfg[31];
      cfg_q.wr_inc  <= node_cfg[30];
      cfg_q.rd_size <= node_cfg[13:12];
      cfg_q.wr_size <= node_cfg[17:16];
      cfg_q.rd_grp  <= node_cfg[23:20];
      cfg_q.wr_grp  <= node_cfg[27:24];
      cfg_q.dir     <= node_cfg[3:2];
      en_q          <= node_cfg[0];
      req_line      <= node_cfg[LINE_LSB +: RLW];
    end else if (en_wr) begin
      en_q <= en_val;
    end
  end

  dma_side_ptr #(.AW(AW), .CW(CW)) rd_ptr_i (
    .clk(clk), .rst(rst), .load(load_ok), .load_addr(node_src), .load_cnt(node_count),
    .inc(rd_inc), .size(cfg_q.rd_size), .step(rd_step),
    .addr(rd_addr), .left(rd_left), .last(rd_last)
  );

  dma_side_ptr #(.AW(AW), .CW(CW)) wr_ptr_i (
    .clk(clk), .rst(rst), .load(load_ok), .load_addr(node_dst), .load_cnt(node_count),
    .inc(wr_inc), .size(cfg_q.wr_size), .step(wr_step),
    .addr(wr_addr), .left(wr_left), .last(wr_last)
  );

  dma_beat_seq #(.AW(AW)) seq_i (
    .clk(clk), .rst(rst), .start(load_ok), .start_empty(node_count == '0),
    .en(en_q), .ack(mem_ack), .rd_grp(cfg_q.rd_grp), .wr_grp(cfg_q.wr_grp),
    .rd_last(rd_last), .rd_empty(rd_left == '0), .wr_last(wr_last),
    .rd_addr(rd_addr), .wr_addr(wr_addr), .rd_size(cfg_q.rd_size), .wr_size(cfg_q.wr_size),
    .busy(busy), .done(node_done), .req(mem_req), .we(mem_we), .addr(mem_addr),
    .size(mem_size), .rd_step(rd_step), .wr_step(wr_step)
  );

  assign cur_count = CNT_W'(wr_left);

  assert_load_ignored_R2: assert property (@(posedge clk) disable iff (rst)
    (busy && node_load && !en_wr) |=> ($stable(cfg_q) && $stable(en_q) && $stable(req_line)));

  assert_no_step_idle_R3: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req);

endmodule

// File: tb/dma_xfer_engine_tb.sv
module dma_xfer_engine_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        node_load;
  logic [12:0] node_count;
  logic [31:0] node_src, node_dst, node_cfg;
  logic        en_wr, en_val;
  logic        busy, node_done;
  logic [15:0] cur_count;
  logic [3:0]  req_line;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr;
  logic [1:0]  mem_size;
  logic        mem_ack;

  always #4 clk = ~clk;

  dma_xfer_engine dut_i (
    .clk(clk), .rst(rst), .node_load(node_load), .node_count(node_count),
    .node_src(node_src), .node_dst(node_dst), .node_cfg(node_cfg),
    .en_wr(en_wr), .en_val(en_val), .busy(busy), .node_done(node_done),
    .cur_count(cur_count), .req_line(req_line), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_size(mem_size), .mem_ack(mem_ack)
  );

  typedef struct {
    logic        we;
    logic [31:0] addr;
    logic [1:0]  size;
    int          rem;
  } beat_t;

  beat_t expq[$];
  int checks = 0, fails = 0, done_cnt = 0;
  int stall_set = 0, stall_cnt = 0, pend_rem = -1;
  bit monitor_on = 1'b0;

  task automatic check_eq(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_cfg(bit si, bit di, int rsz, int wsz, int rg, int wg,
                                         int dir, int line, bit en);
    logic [31:0] c;
    c = '0;
    c[31] = si; c[30] = di;
    c[13:12] = rsz[1:0]; c[17:16] = wsz[1:0];
    c[23:20] = rg[3:0];  c[27:24] = wg[3:0];
    c[3:2] = dir[1:0];   c[7:4] = line[3:0];
    c[0] = en;
    return c;
  endfunction

  // driver: model the expected beat stream from the requirements
  task automatic push_node(input logic [31:0] s, input logic [31:0] d, input int cnt,
                           input logic [31:0] c);
    int sw, dw, sg, dg, rl, wl, n, dir;
    bit si, di;
    beat_t b;
    sw = 1 << c[13:12]; dw = 1 << c[17:16];
    sg = c[23:20]; dg = c[27:24]; dir = c[3:2];
    si = c[31] && dir != 2; di = c[30] && dir != 1;
    rl = cnt; wl = cnt;
    while (wl > 0) begin
      n = 0;
      while (rl > 0 && n <= sg) begin
        b.we = 0; b.addr = s; b.size = c[13:12]; b.rem = 0;
        expq.push_back(b);
        rl -= (rl < sw) ? rl : sw;
        if (si) s += sw;
        n++;
      end
      n = 0;
      while (wl > 0 && n <= dg) begin
        wl -= (wl < dw) ? wl : dw;
        b.we = 1; b.addr = d; b.size = c[17:16]; b.rem = wl;
        expq.push_back(b);
        if (di) d += dw;
        n++;
      end
    end
  endtask

  task automatic load_node(input logic [31:0] s, input logic [31:0] d, input int cnt,
                           input logic [31:0] c);
    @(negedge clk);
    node_src = s; node_dst = d; node_count = cnt[12:0]; node_cfg = c; node_load = 1'b1;
    @(negedge clk);
    node_load = 1'b0;
  endtask

  task automatic run_node(input logic [31:0] s, input logic [31:0] d, input int cnt,
                          input logic [31:0] c, input string tag);
    int base;
    base = done_cnt;
    push_node(s, d, cnt, c);
    load_node(s, d, cnt, c);
    wait_done(base + 1, tag);
  endtask

  task automatic wait_done(input int target, input string tag);
    for (int i = 0; i < 40000 && done_cnt < target; i++) @(negedge clk);
    check_eq({tag, " R8 node completed"}, done_cnt, target);
    check_eq({tag, " R3 all beats seen"}, expq.size(), 0);
    check_eq({tag, " R6 count drained"}, cur_count, 0);
  endtask

  // monitor: acknowledge requests and compare against the scoreboard
  always @(negedge clk) begin
    if (monitor_on) begin
      if (pend_rem >= 0) begin
        check_eq("R6 remaining after write", cur_count, pend_rem);
        pend_rem = -1;
      end
      if (node_done) begin
        done_cnt++;
        check_eq("R8 busy low with done", busy, 0);
      end
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req) begin
        if (stall_cnt > 0) stall_cnt--;
        else begin
          if (expq.size() == 0) begin
            check_eq("R2/R3 unexpected beat addr", mem_addr, 32'hDEAD_BEEF);
          end else begin
            beat_t e;
            e = expq.pop_front();
            check_eq("R3 beat direction", mem_we, e.we);
            check_eq("R4/R5 beat address", mem_addr, e.addr);
            check_eq("R3 beat size", mem_size, e.size);
            if (e.we) pend_rem = e.rem;
          end
          mem_ack = 1'b1;
          stall_cnt = stall_set;
        end
      end
    end
  end

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    int base, snap, qsz;
    rst = 1'b1; node_load = 1'b0; node_count = '0; node_src = '0; node_dst = '0;
    node_cfg = '0; en_wr = 1'b0; en_val = 1'b0; mem_ack = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check_eq("R1 busy", busy, 0);
    check_eq("R1 req", mem_req, 0);
    check_eq("R1 done", node_done, 0);
    check_eq("R1 count", cur_count, 0);
    check_eq("R1 line", req_line, 0);
    monitor_on = 1'b1;

    // R3 R4: memory to memory, 4-byte both sides, groups of 4
    run_node(32'h1000, 32'h2000, 32, mk_cfg(1, 1, 2, 2, 3, 3, 0, 1, 1), "m2m");

    // R3: narrow reads feed wide writes, different group lengths
    stall_set = 2;
    run_node(32'h3001, 32'h4000, 12, mk_cfg(1, 1, 0, 2, 3, 0, 0, 2, 1), "narrow");

    // R5: memory to peripheral, write side held although cfg[30] set
    stall_set = 1;
    run_node(32'h5000, 32'h9000_0010, 10, mk_cfg(1, 1, 1, 1, 1, 2, 1, 3, 1), "m2p");

    // R5 R6: peripheral to memory, read held, short final write of 2 bytes
    stall_set = 0;
    run_node(32'h9000_0020, 32'h6000, 6, mk_cfg(1, 1, 2, 2, 0, 0, 2, 4, 1), "p2m");

    // R8: zero count node
    base = done_cnt;
    load_node(32'h0, 32'h0, 0, mk_cfg(1, 1, 2, 2, 0, 0, 0, 5, 1));
    check_eq("R8 zero count done pulse", node_done, 1);
    check_eq("R8 zero count not busy", busy, 0);
    repeat (3) @(negedge clk);
    check_eq("R8 zero count single pulse", done_cnt, base + 1);
    check_eq("R8 zero count no beats", mem_req, 0);

    // R7 R10: node loaded disabled, then enabled
    base = done_cnt;
    push_node(32'h7000, 32'h7800, 16, mk_cfg(1, 1, 2, 2, 1, 1, 0, 10, 0));
    load_node(32'h7000, 32'h7800, 16, mk_cfg(1, 1, 2, 2, 1, 1, 0, 10, 0));
    repeat (5) @(negedge clk);
    check_eq("R10 request line", req_line, 4'hA);
    check_eq("R7 disabled node busy", busy, 1);
    check_eq("R7 disabled node no request", mem_req, 0);
    check_eq("R7 disabled node count held", cur_count, 16);
    en_wr = 1'b1; en_val = 1'b1;
    @(negedge clk);
    en_wr = 1'b0;
    wait_done(base + 1, "enable");

    // R7: pause in mid stream and resume
    stall_set = 1;
    base = done_cnt;
    push_node(32'h8000, 32'h8800, 64, mk_cfg(1, 1, 2, 2, 1, 1, 0, 6, 1));
    load_node(32'h8000, 32'h8800, 64, mk_cfg(1, 1, 2, 2, 1, 1, 0, 6, 1));
    repeat (12) @(negedge clk);
    en_wr = 1'b1; en_val = 1'b0;
    @(negedge clk);
    en_wr = 1'b0;
    repeat (6) @(negedge clk);
    snap = cur_count; qsz = expq.size();
    begin
      bit quiet;
      quiet = 1'b1;
      for (int i = 0; i < 8; i++) begin
        if (mem_req) quiet = 1'b0;
        @(negedge clk);
      end
      check_eq("R7 no request while paused", quiet, 1);
    end
    check_eq("R7 count held while paused", cur_count, snap);
    check_eq("R7 no beats while paused", expq.size(), qsz);
    check_eq("R7 still busy while paused", busy, 1);
    en_wr = 1'b1; en_val = 1'b1;
    @(negedge clk);
    en_wr = 1'b0;
    wait_done(base + 1, "resume");

    // R2: load while busy is ignored
    stall_set = 0;
    base = done_cnt;
    push_node(32'hA000, 32'hB000, 40, mk_cfg(1, 1, 2, 2, 2, 2, 0, 7, 1));
    load_node(32'hA000, 32'hB000, 40, mk_cfg(1, 1, 2, 2, 2, 2, 0, 7, 1));
    repeat (3) @(negedge clk);
    snap = cur_count;
    load_node(32'hC000, 32'hD000, 256, mk_cfg(0, 0, 0, 0, 0, 0, 0, 9, 1));
    check_eq("R2 count not reloaded", cur_count <= snap, 1);
    check_eq("R2 line unchanged", req_line, 7);
    wait_done(base + 1, "busy load");
    repeat (20) @(negedge clk);
    check_eq("R2 single done pulse", done_cnt, base + 1);

    // R6: largest count, 8-byte beats, 16-beat groups
    run_node(32'h1_0000, 32'h2_0000, 13'h1FFC, mk_cfg(1, 1, 3, 3, 15, 15, 0, 8, 1), "max");

    repeat (4) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule